// File: doc/BRIEF.md
# Interrupting GPIO Controller

A memory-mapped general-purpose I/O block for up to twelve pins, read and written through a simple 32-bit register port: byte address, write strobe, write data and combinational read data. Each pin has an output latch, a direction bit and a synchronized input readback. Each pin also has its own event detector, programmable for rising edge, falling edge, either edge, high level or low level.

Events from enabled pins latch into a status register. Software acknowledges them by writing ones to a clear address. A mask, set and cleared through two separate write-one addresses, gates latched status onto one combined interrupt line. A masked view of status can be read back. A soft-reset register holds every configuration and status register at its reset value for as long as its bit is 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word registers are decoded from addr_i[5:2] at these byte offsets: 0x00 enable, 0x04 status, 0x08 masked status, 0x0C clear, 0x10 mask set, 0x14 mask clear, 0x18 output, 0x1C input, 0x20 direction, 0x24 mode low, 0x28 mode high, 0x3C soft reset. Every other offset reads zero and ignores writes. Writes to the status, masked status and input offsets have no effect.
- R2: pin_o equals the output register and pin_oe_o equals the direction register, where 1 means drive. Only bits 0 to 11 are stored, and bits 31 to 12 of the direction and output registers read zero.
- R3: The input register returns pin_i after two synchronizing flops. A level applied before a clock edge is readable after the second edge.
- R4: Each pin has a 3-bit trigger code: 000 falling edge, 001 rising edge, 010 low level, 011 high level, 1xx either edge. Pin p of 0 to 7 sits in mode low at bits p*4+2..p*4. Pin p of 8 to 11 sits in mode high at bits (p-8)*4+2..(p-8)*4. The fourth bit of each nibble reads zero.
- R5: For an enabled pin in an edge mode, status sets on the third clock edge after the pin changes in the programmed direction. It does not set while the synchronized level is steady.
- R6: For an enabled pin in a level mode, status sets on every cycle that the synchronized level matches. A clear written while the level persists leaves the bit set.
- R7: A pin whose enable bit is 0 never sets its status bit.
- R8: Writing 1 to a bit of the clear offset clears that status bit unless an event for that pin occurs in the same cycle. Zero bits leave status unchanged.
- R9: Writing 1 to a bit at 0x10 sets that mask bit and writing 1 at 0x14 clears it. Zero bits change nothing. Both offsets read the current mask.
- R10: The masked-status register reads status AND enable AND NOT mask. irq_o is the OR of that value across all pins.
- R11: Writing 1 to bit 0 of the soft-reset offset holds enable, status, mask, output, direction and modes at zero from the following cycle, and ignores writes to them. Writing 0 releases the hold. Bit 0 reads back the written value.
- R12: After rst_ni, every register reads zero, irq_o is 0 and no pin drives.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NPINS | Pin levels from the pads |
| pin_o | output | NPINS | Output levels to the pads |
| pin_oe_o | output | NPINS | Drive enables to the pads |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets three corner cases.

- **Level re-assertion after clear.** A design that lets a clear win over a persisting level would read the bit as 0 for one cycle and drop the interrupt.
- **Mode-field packing across both mode registers.** The bench uses pin 8 in the high register. A misplaced nibble would either miss its edge or fire a different pin.
- **Events on a disabled pin.** Latching such an event into status would raise an interrupt the moment enable is set.

The bench also walks the soft-reset hold, which must take effect one cycle after the write and swallow writes made while the hold is active. It checks the mask set and clear addresses with zero bits, which must leave other mask bits alone.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [3:0] {
    REG_EN    = 4'd0,
    REG_STAT  = 4'd1,
    REG_DISP  = 4'd2,
    REG_CLR   = 4'd3,
    REG_MSET  = 4'd4,
    REG_MCLR  = 4'd5,
    REG_OUT   = 4'd6,
    REG_IN    = 4'd7,
    REG_DIR   = 4'd8,
    REG_MODE0 = 4'd9,
    REG_MODE1 = 4'd10,
    REG_SRST  = 4'd15
  } reg_idx_e;

  localparam logic [2:0] TRIG_FALL = 3'b000;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_LOW  = 3'b010;
  localparam logic [2:0] TRIG_HIGH = 3'b011;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_trig.sv
module gpio_irq_trig
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  output logic       evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    if (mode_i[2]) evt_o = lvl_i ^ prev_q;
    else begin
      case (mode_i)
        TRIG_FALL: evt_o = prev_q & ~lvl_i;
        TRIG_RISE: evt_o = lvl_i & ~prev_q;
        TRIG_LOW:  evt_o = ~lvl_i;
        default:   evt_o = lvl_i;
      endcase
    end
  end

  AST_EDGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2] && (lvl_i == prev_q)) |-> !evt_o); // R5
  AST_LEVEL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_HIGH && lvl_i) |-> evt_o); // R6
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned PER_MODE = 8;
  localparam int unsigned NMODE    = (NPINS + PER_MODE - 1) / PER_MODE;

  logic [NPINS-1:0]      en_q, stat_q, mask_q, out_q, dir_q;
  logic [NPINS-1:0][2:0] mode_q;
  logic                  srst_q;
  logic [NPINS-1:0]      lvl_s, evt, wd, clr_w, disp;
  reg_idx_e              widx;
  logic                  unused_ok;

  assign widx      = reg_idx_e'(addr_i[5:2]);
  assign wd        = wdata_i[NPINS-1:0];
  assign clr_w     = (we_i && widx == REG_CLR) ? wd : '0;
  assign unused_ok = ^{addr_i[1:0], wdata_i};

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl_s)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_trig
    gpio_irq_trig u_trig (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl_s[g]),
      .mode_i(mode_q[g]),
      .evt_o (evt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      stat_q <= '0;
      mask_q <= '0;
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      if (we_i && widx == REG_SRST) srst_q <= wdata_i[0];
      if (srst_q) begin
        en_q   <= '0;
        stat_q <= '0;
        mask_q <= '0;
        out_q  <= '0;
        dir_q  <= '0;
        mode_q <= '0;
      end else begin
        // new events win over a same-cycle clear
        stat_q <= (stat_q & ~clr_w) | (evt & en_q);
        if (we_i) begin
          case (widx)
            REG_EN:   en_q   <= wd;
            REG_MSET: mask_q <= mask_q | wd;
            REG_MCLR: mask_q <= mask_q & ~wd;
            REG_OUT:  out_q  <= wd;
            REG_DIR:  dir_q  <= wd;
            default:  ;
          endcase
        end
        for (int p = 0; p < NPINS; p++) begin
          if (we_i && int'(addr_i[5:2]) == int'(REG_MODE0) + p / PER_MODE)
            mode_q[p] <= wdata_i[(p % PER_MODE) * 4 +: 3];
        end
      end
    end
  end

  assign disp     = stat_q & en_q & ~mask_q;
  assign irq_o    = |disp;
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  always_comb begin
    rdata_o = '0;
    case (widx)
      REG_EN:             rdata_o[NPINS-1:0] = en_q;
      REG_STAT:           rdata_o[NPINS-1:0] = stat_q;
      REG_DISP:           rdata_o[NPINS-1:0] = disp;
      REG_MSET, REG_MCLR: rdata_o[NPINS-1:0] = mask_q;
      REG_OUT:            rdata_o[NPINS-1:0] = out_q;
      REG_IN:             rdata_o[NPINS-1:0] = lvl_s;
      REG_DIR:            rdata_o[NPINS-1:0] = dir_q;
      REG_MODE0, REG_MODE1: begin
        for (int p = 0; p < NPINS; p++) begin
          if (p / PER_MODE == int'(widx) - int'(REG_MODE0))
            rdata_o[(p % PER_MODE) * 4 +: 3] = mode_q[p];
        end
      end
      REG_SRST:           rdata_o[0] = srst_q;
      default:            ;
    endcase
  end

  initial begin
    if (NMODE > 2 || NPINS > DATA_W) $error("NPINS too large for the register map");
  end

  AST_STAT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0)); // R7
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == REG_CLR && !srst_q) |=>
      ((stat_q & $past(wd) & ~$past(evt & en_q)) == '0)); // R8
  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == REG_MSET && !srst_q) |=> ((mask_q & $past(wd)) == $past(wd))); // R9
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx == REG_MCLR && !srst_q) |=> ((mask_q & $past(wd)) == '0)); // R9
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(stat_q & ~mask_q))); // R10
  AST_SRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (en_q == '0 && stat_q == '0 && mask_q == '0 && dir_q == '0)); // R11
  AST_DIR_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == REG_DIR) |-> (rdata_o[DATA_W-1:NPINS] == '0)); // R2
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pin = '0;
  logic [N-1:0] pin_o, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference state
  logic [N-1:0] m_en, m_st, m_mk, m_out, m_dir, m_s1, m_s2, m_pv;
  logic [2:0]   m_mode [N];
  logic         m_srst;

  function automatic logic m_evt(int p);
    logic now, was;
    now = m_s2[p];
    was = m_pv[p];
    if (m_mode[p][2]) return now != was;
    case (m_mode[p][1:0])
      2'd0:    return was && !now;
      2'd1:    return now && !was;
      2'd2:    return !now;
      default: return now;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    logic [31:0] r;
    r = '0;
    case (int'(a[5:2]))
      0:  r[N-1:0] = m_en;
      1:  r[N-1:0] = m_st;
      2:  r[N-1:0] = m_st & m_en & ~m_mk;
      4, 5: r[N-1:0] = m_mk;
      6:  r[N-1:0] = m_out;
      7:  r[N-1:0] = m_s2;
      8:  r[N-1:0] = m_dir;
      9:  for (int p = 0; p < 8; p++) r[p*4 +: 3] = m_mode[p];
      10: for (int p = 8; p < N; p++) r[(p-8)*4 +: 3] = m_mode[p];
      15: r[0] = m_srst;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [5:0] a);
    case (int'(a[5:2]))
      0: return "R7";
      1: return "R5";
      2: return "R10";
      4, 5: return "R9";
      6, 8: return "R2";
      7: return "R3";
      9, 10: return "R4";
      15: return "R11";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = '0; m_st = '0; m_mk = '0; m_out = '0; m_dir = '0;
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_srst = 1'b0;
      for (int p = 0; p < N; p++) m_mode[p] = '0;
    end else begin
      logic [N-1:0] ev, clr;
      int w;
      for (int p = 0; p < N; p++) ev[p] = m_evt(p);
      w = int'(addr[5:2]);
      clr = (we && w == 3) ? wdata[N-1:0] : '0;
      if (m_srst) begin
        m_en = '0; m_st = '0; m_mk = '0; m_out = '0; m_dir = '0;
        for (int p = 0; p < N; p++) m_mode[p] = '0;
      end else begin
        m_st = (m_st & ~clr) | (ev & m_en);
        if (we) begin
          if (w == 0) m_en = wdata[N-1:0];
          if (w == 4) m_mk = m_mk | wdata[N-1:0];
          if (w == 5) m_mk = m_mk & ~wdata[N-1:0];
          if (w == 6) m_out = wdata[N-1:0];
          if (w == 8) m_dir = wdata[N-1:0];
          if (w == 9) for (int p = 0; p < 8; p++) m_mode[p] = wdata[p*4 +: 3];
          if (w == 10) for (int p = 8; p < N; p++) m_mode[p] = wdata[(p-8)*4 +: 3];
        end
      end
      if (we && w == 15) m_srst = wdata[0];
      m_pv = m_s2;
      m_s2 = m_s1;
      m_s1 = pin;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    #2;
    if (rst_ni && !done) begin
      chk(req_of(addr), rdata, m_read(addr));
      chk("R2", 32'(pin_o), 32'(m_out));
      chk("R2", 32'(pin_oe), 32'(m_dir));
      chk("R10", 32'(irq), 32'(|(m_st & m_en & ~m_mk)));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    #1 we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic set_pin(logic [N-1:0] v, int settle);
    @(negedge clk);
    pin = v;
    cyc(settle);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    // R12: everything zero after reset
    for (int i = 0; i < 16; i++) rd_chk("R12", 6'(i*4), 32'h0);
    @(negedge clk);
    #1 chk("R12", {irq, 7'b0, 12'(pin_oe), 12'(pin_o)}, 32'h0);

    // R2: output and direction
    wr(6'h18, 32'h0000_0A5A);
    wr(6'h20, 32'hFFFF_FFFF);
    rd_chk("R2", 6'h20, 32'h0000_0FFF);
    rd_chk("R2", 6'h18, 32'h0000_0A5A);
    @(negedge clk);
    #1 chk("R2", 32'(pin_o), 32'h0A5A);
    chk("R2", 32'(pin_oe), 32'h0FFF);

    // R3: synchronized input
    set_pin(12'h3C5, 3);
    rd_chk("R3", 6'h1C, 32'h0000_03C5);

    // R1: read-only and unmapped offsets
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h1C, 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF);
    rd_chk("R1", 6'h04, 32'h0);
    rd_chk("R1", 6'h1C, 32'h0000_03C5);
    rd_chk("R1", 6'h2C, 32'h0);
    rd_chk("R1", 6'h34, 32'h0);

    // R4: mode packing
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h28, 32'hFFFF_FFFF);
    rd_chk("R4", 6'h24, 32'h7777_7777);
    rd_chk("R4", 6'h28, 32'h0000_7777);
    // p0 rise, p1 fall, p2 both, p3 high, p4 low, p8 rise
    wr(6'h24, 32'h0002_3401);
    wr(6'h28, 32'h0000_0001);
    rd_chk("R4", 6'h24, 32'h0002_3401);

    // R7: disabled pin does not latch
    set_pin(12'h000, 4);
    set_pin(12'h001, 4);
    rd_chk("R7", 6'h04, 32'h0);
    set_pin(12'h000, 4);
    wr(6'h00, 32'h0000_010F);
    wr(6'h0C, 32'h0000_0FFF);
    rd_chk("R7", 6'h04, 32'h0);

    // R5: edges
    set_pin(12'h001, 4);
    rd_chk("R5", 6'h04, 32'h001);
    set_pin(12'h005, 4);
    rd_chk("R5", 6'h04, 32'h005);
    set_pin(12'h001, 4);
    wr(6'h0C, 32'h0000_0FFF);
    rd_chk("R5", 6'h04, 32'h0);
    set_pin(12'h000, 4);
    set_pin(12'h002, 4);
    rd_chk("R5", 6'h04, 32'h0);
    set_pin(12'h000, 4);
    rd_chk("R5", 6'h04, 32'h002);
    set_pin(12'h100, 4);
    rd_chk("R4", 6'h04, 32'h102);

    // R8: write-one clear
    wr(6'h0C, 32'h0000_0002);
    rd_chk("R8", 6'h04, 32'h100);
    wr(6'h0C, 32'h0);
    rd_chk("R8", 6'h04, 32'h100);

    // R6: level persists through clear
    set_pin(12'h108, 4);
    rd_chk("R6", 6'h04, 32'h108);
    wr(6'h0C, 32'h0000_0008);
    rd_chk("R6", 6'h04, 32'h108);
    set_pin(12'h100, 4);
    wr(6'h0C, 32'h0000_0008);
    rd_chk("R6", 6'h04, 32'h100);
    wr(6'h00, 32'h0000_011F);
    cyc(1);
    rd_chk("R6", 6'h04, 32'h110);

    // R9 / R10: mask and combined interrupt
    @(negedge clk);
    #1 chk("R10", 32'(irq), 32'h1);
    wr(6'h10, 32'h0000_0110);
    rd_chk("R9", 6'h14, 32'h110);
    rd_chk("R10", 6'h08, 32'h0);
    #0 chk("R10", 32'(irq), 32'h0);
    wr(6'h14, 32'h0000_0100);
    wr(6'h10, 32'h0);
    rd_chk("R9", 6'h10, 32'h010);
    rd_chk("R10", 6'h08, 32'h100);
    #0 chk("R10", 32'(irq), 32'h1);

    // R11: soft reset hold
    wr(6'h3C, 32'h1);
    cyc(1);
    rd_chk("R11", 6'h00, 32'h0);
    wr(6'h00, 32'h0000_0FFF);
    rd_chk("R11", 6'h00, 32'h0);
    rd_chk("R11", 6'h3C, 32'h1);
    wr(6'h3C, 32'h0);
    rd_chk("R11", 6'h3C, 32'h0);
    rd_chk("R11", 6'h04, 32'h0);
    rd_chk("R11", 6'h10, 32'h0);
    rd_chk("R11", 6'h24, 32'h0);
    #0 chk("R11", {12'(pin_oe), 8'b0, 12'(pin_o)}, 32'h0);
    #0 chk("R11", 32'(irq), 32'h0);
    wr(6'h00, 32'h0000_0003);
    rd_chk("R11", 6'h00, 32'h3);

    cyc(4);
    finish_run();
  end
endmodule